// File: doc/BRIEF.md
# MDIO Management Command Register

This block is a clause 22 MDIO management master. Software controls all of it through one 32-bit command word. To start an access, software writes a word with the request flag set, the direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then sends a complete management frame on MDC/MDIO. At the end of the frame it clears the request flag. For a read it also replaces the low 16 bits of the word with the value the PHY returned.

MDC is made from the system clock by a divider set with a parameter. Each bit period is CLK_HALF cycles with MDC low, followed by CLK_HALF cycles with MDC high. The block drives MDIO while MDC is low and samples it when MDC rises. When idle it holds MDC low, releases the output enable and keeps its MDIO output at one. The output enable and data are meant to drive an external tri-state pad.

Top module: `mdio_cmd_reg`

## Requirements
- R1: After reset the command word reads 0, MDC is low, mdio_oe is 0 and mdio_o is 1. Whenever bit 31 reads 0, MDC is low, mdio_oe is 0 and mdio_o is 1.
- R2: A write with bit 31 set, made while no access is in progress, stores the word and starts a frame on the next clock. Bit 31 then reads 1 until the frame ends. The first bit of the frame is a driven one with MDC low.
- R3: The frame is 64 bits long, MSB first. It consists of 32 ones, then 0 and 1, then the opcode (0,1 when bit 30 = 1 for a write; 1,0 when bit 30 = 0 for a read), then the PHY address from bits 25:21, then the register address from bits 20:16, then the turnaround, then 16 data bits. For a write the turnaround is 1,0 and the data bits come from bits 15:0.
- R4: Each bit lasts 2*CLK_HALF clocks. MDC is low for the first CLK_HALF clocks and high for the rest. mdio_o and mdio_oe change only while MDC is low.
- R5: For a write, mdio_oe stays 1 for the whole frame. For a read, mdio_oe is 1 through the register address and 0 from the first turnaround bit until the frame ends.
- R6: During a read, the 16 data bits are sampled from mdio_i when MDC rises, MSB first. At completion they are placed in bits 15:0 of the command word.
- R7: Bit 31 clears on the clock that ends the high phase of bit 63. Bits 30:16 are kept, and so are bits 15:0 after a write.
- R8: A write to the command word while bit 31 reads 1 has no effect on the word or on the frame in progress.
- R9: A write with bit 31 clear, made while idle, updates the stored word and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Value to write into the command word |
| cmd_rdata | output | 32 | Current command word: request, direction, addresses, data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, 1 drives the pad |
| mdio_i | input | 1 | MDIO value read back from the pad |

## Verification
The bench builds the block with CLK_HALF = 2, so every MDC phase lasts two system clocks. A frame is then short enough that several complete reads and writes fit in one run, and every one of the 64 bit positions is compared cycle by cycle. The PHY model inverts mdio_i during the MDC high phase. Because each phase has more than one cycle, sampling in the wrong cycle or on the falling edge would return corrupted read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Field widths of a clause 22 management frame
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
  localparam int CMD_W    = 32;

  // Frame layout (bit index counted from the first transmitted bit)
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_IDX    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_IDX  = TA_IDX + 2;

  // Command word, packed so that field positions follow the software view
  typedef struct packed {
    logic              req;
    logic              wr;
    logic [3:0]        spare;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] data;
  } cmd_t;

  localparam int REQ_BIT = CMD_W - 1;

  // Builds the transmit image; positions the master does not drive are ones
  function automatic logic [FRAME_LEN-1:0] mdio_build_frame(
    input logic              is_wr,
    input logic [PHY_W-1:0]  phy,
    input logic [REG_W-1:0]  regad,
    input logic [DATA_W-1:0] data
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    op  = is_wr ? 2'b01 : 2'b10;
    ta  = is_wr ? 2'b10 : 2'b11;
    dat = is_wr ? data : {DATA_W{1'b1}};
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int CLK_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int PERIOD = 2 * CLK_HALF;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(CLK_HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign rise_stb = run && (cnt == RISE_AT);
  assign fall_stb = run && (cnt == FALL_AT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      if (fall_stb) cnt <= '0;
      else          cnt <= cnt + 1'b1;
      if (rise_stb)      mdc <= 1'b1;
      else if (fall_stb) mdc <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic [PHY_W-1:0]  start_phy,
  input  logic [REG_W-1:0]  start_reg,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_LEN - 1);
  localparam logic [BW-1:0] TA_PREV    = BW'(TA_IDX - 1);
  localparam logic [BW-1:0] DATA_FIRST = BW'(DATA_IDX);

  logic [FRAME_LEN-1:0] shreg;
  logic [BW-1:0]        bit_cnt;
  logic                 is_rd;

  assign done   = busy && fall_stb && (bit_cnt == LAST_BIT);
  assign mdio_o = shreg[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      is_rd   <= 1'b0;
      shreg   <= '1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
      is_rd   <= !start_wr;
      shreg   <= mdio_build_frame(start_wr, start_phy, start_reg, start_data);
      mdio_oe <= 1'b1;
      rd_data <= '0;
    end else if (busy) begin
      if (rise_stb && is_rd && (bit_cnt >= DATA_FIRST))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (bit_cnt == LAST_BIT) begin
          busy    <= 1'b0;
          bit_cnt <= '0;
          shreg   <= '1;
          mdio_oe <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {shreg[FRAME_LEN-2:0], 1'b1};
          if (is_rd && (bit_cnt == TA_PREV)) mdio_oe <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
#(
  parameter int CLK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  cmd_t              cmd_q;
  cmd_t              wcmd;
  logic              busy;
  logic              done;
  logic              start;
  logic              rise_stb;
  logic              fall_stb;
  logic [DATA_W-1:0] rd_data;

  assign wcmd      = cmd_t'(cmd_wdata);
  assign start     = cmd_we && !busy && cmd_wdata[REQ_BIT];
  assign cmd_rdata = cmd_q;

  mdio_mdc_div #(.CLK_HALF(CLK_HALF)) i_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine i_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_wr   (wcmd.wr),
    .start_phy  (wcmd.phy),
    .start_reg  (wcmd.regad),
    .start_data (wcmd.data),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .done       (done),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (done) begin
      cmd_q.req <= 1'b0;
      if (!cmd_q.wr) cmd_q.data <= rd_data;
    end else if (cmd_we && !busy) begin
      cmd_q <= wcmd;
    end
  end

endmodule

// File: rtl/mdio_cmd_reg_chk.sv
module mdio_cmd_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  // R1: idle line is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdata[31] |-> (!mdc && !mdio_oe && mdio_o));

  // R2: a frame opens with a driven one, MDC low
  p_start_high_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_rdata[31]) |-> (mdio_o && mdio_oe && !mdc));

  // R4: data and enable hold while MDC is high
  p_hold_high_r4: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R5: writes drive the line for the whole frame
  p_write_drives_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[31] && cmd_rdata[30]) |-> mdio_oe);

  // R7: completion follows an MDC high phase
  p_end_after_high_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_rdata[31]) |-> $past(mdc));

  // R8: fields are frozen while a frame runs
  p_fields_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_rdata[31] |=> (cmd_rdata[30:16] == $past(cmd_rdata[30:16])));

endmodule

bind mdio_cmd_reg mdio_cmd_reg_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_rdata (cmd_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_cmd_reg.sv
module test_mdio_cmd_reg;

  localparam int H   = 2;
  localparam int BC  = 2 * H;
  localparam int FL  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we  = 1'b0;
  logic [31:0] wd  = '0;
  logic        mi  = 1'b1;
  wire  [31:0] rdq;
  wire         mdc, mo, moe;

  always #5 clk = ~clk;

  mdio_cmd_reg #(.CLK_HALF(H)) i_mdio_cmd_reg (
    .clk(clk), .rst(rst), .cmd_we(we), .cmd_wdata(wd), .cmd_rdata(rdq),
    .mdc(mdc), .mdio_o(mo), .mdio_oe(moe), .mdio_i(mi)
  );

  int n_run  = 0;
  int n_fail = 0;

  // reference model state
  logic [31:0] m_reg = '0;
  bit          m_busy = 0;
  int          m_c = 0;
  bit          m_rd = 0;
  logic [15:0] phy_val = 16'h0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected transmitted bit b of the current frame (R3)
  function automatic logic exp_bit(input int b);
    if (b < 32)  return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return m_rd ? 1'b1 : 1'b0;
    if (b == 35) return m_rd ? 1'b0 : 1'b1;
    if (b <= 40) return m_reg[25 - (b - 36)];
    if (b <= 45) return m_reg[20 - (b - 41)];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_reg[15 - (b - 48)];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg = '0; m_busy = 0; m_c = 0;
    end else if (m_busy) begin
      m_c++;
      if (m_c == FL * BC) begin
        m_busy = 0;
        m_reg[31] = 1'b0;
        if (m_rd) m_reg[15:0] = phy_val;
      end
    end else if (we) begin
      m_reg = wd;
      if (wd[31]) begin
        m_busy = 1; m_c = 0; m_rd = !wd[30];
      end
    end
  end

  // compare every clock, then drive the PHY side
  always @(negedge clk) begin
    if (!rst) begin
      int b;
      logic e_mdc, e_oe;
      b = m_c / BC;
      e_mdc = m_busy && ((m_c % BC) >= H);
      e_oe  = m_busy && !(m_rd && b >= 46);
      chk(mdc == e_mdc, "R4 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk(moe == e_oe, "R5 mdio_oe", {31'd0, moe}, {31'd0, e_oe});
      if (!m_busy)   chk(mo == 1'b1, "R1 idle mdio_o", {31'd0, mo}, 32'd1);
      else if (e_oe) chk(mo == exp_bit(b), "R3 frame bit", {31'd0, mo}, {31'd0, exp_bit(b)});
      chk(rdq == m_reg, "R7 command word", rdq, m_reg);
      if (m_busy && m_rd && b >= 48)
        mi = ((m_c % BC) < H) ? phy_val[63 - b] : ~phy_val[63 - b];
      else
        mi = 1'b1;
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (rdq[31]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rdq == 32'd0 && !mdc && !moe && mo, "R1 reset", rdq, 32'd0);

    // R2 write to PHY 5 register 0
    wr(32'hC0A0_9000);
    chk(rdq[31] == 1'b1, "R2 request held", rdq, 32'hC0A0_9000);
    wait_idle();
    chk(rdq == 32'h40A0_9000, "R7 write completion", rdq, 32'h40A0_9000);

    // R6 read PHY 6 register 1, with R8 write while busy
    phy_val = 16'hA5C3;
    wr(32'h80C1_0000);
    repeat (20) @(negedge clk);
    wr(32'hC3FF_1234);
    chk(rdq[30:16] == 15'h00C1, "R8 write ignored while busy", {17'd0, rdq[30:16]}, 32'h00C1);
    wait_idle();
    chk(rdq[15:0] == 16'hA5C3, "R6 read data", {16'd0, rdq[15:0]}, 32'hA5C3);

    // R9 idle write without request
    wr(32'h0012_3456);
    repeat (12) @(negedge clk);
    chk(rdq == 32'h0012_3456 && !moe && !mdc, "R9 no frame", rdq, 32'h0012_3456);

    // R6 read with all-ones addresses and edge data
    phy_val = 16'h8001;
    wr(32'h83FF_0000);
    wait_idle();
    chk(rdq == 32'h03FF_8001, "R6 read edge pattern", rdq, 32'h03FF_8001);

    // R3 write to PHY 6 register 0
    wr(32'hC0C0_9000);
    wait_idle();
    chk(rdq == 32'h40C0_9000, "R3 second write", rdq, 32'h40C0_9000);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule